// File: doc/BRIEF.md
# Sector Buffer Host Word Reader

This block lets a processor pull a sector out of a byte-wide buffer as a stream of 16-bit words. The controller's register block loads a byte address and a signed byte count, then starts a transfer and names which of two processors, main or sub, is to read it. Each read strobe returns a big-endian word one cycle later. The upper byte comes from the even address and the lower byte from the odd address next to it. A read advances the address and the count only when it comes from the processor that the transfer names. A read from the other processor sees the same word and leaves all state alone.

The block drives the handshake flags the host polls. A data-ready flag is raised when a transfer starts. An end-of-transfer flag is raised when the transfer is about to finish. The block also keeps a pending transfer-end event. That event, and an optional one-cycle interrupt request, fire one word before the final read, when one or two bytes remain. The final read reloads the count with a marker value whose upper bits are all ones and closes the transfer. The buffer is a synchronous RAM of 2^AW bytes. AW is 14 for a full 16 KB buffer. It has a byte-wide preload port.

Top module: `shr_host_port`

## Requirements
- R1: A pulse on `trig` with `dest` equal to 2 (main) or 3 (sub) sets `xfer_on`, `busy` and `dsr` and clears `edt` on the next edge. A trigger with any other code changes nothing.
- R2: A read strobe while `xfer_on` is high gives, on the next edge, `rd_valid` high and `rd_data` = {byte[addr with bit 0 cleared], byte[addr with bit 0 set]}.
- R3: A read strobe while `xfer_on` is low gives `rd_data` = 0 with `rd_valid` high, and leaves the address, count and flags unchanged.
- R4: A read from the processor the transfer does not name returns the word and leaves the address, count and flags unchanged.
- R5: A read from the named processor adds 2 to the address, wrapping modulo 2^AW, and subtracts 2 from the count.
- R6: When the decremented count is ≤ 0 as a signed 16-bit value, the count becomes 16'hF000, `xfer_on`, `busy` and `dsr` go low, and `edt` goes high.
- R7: When the decremented count is 1 or 2, `dsr` and `edt` go high. If no end event is pending, `end_pend` is set and `end_irq` pulses for one cycle when `irq_en` is high.
- R8: `end_ack` clears `end_pend`. A near-end read while `end_pend` is already high gives no `end_irq` pulse.
- R9: `ld_addr_en` and `ld_cnt_en` load the address and count. A preload write stores `pre_data` at `pre_addr`.
- R10: After reset, every flag, `end_irq`, `rd_valid`, `rd_data`, the address and the count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_we | input | 1 | Buffer preload write strobe |
| pre_addr | input | AW | Preload byte address |
| pre_data | input | 8 | Preload byte |
| ld_addr_en | input | 1 | Load the address counter |
| ld_addr | input | AW | Address load value |
| ld_cnt_en | input | 1 | Load the byte counter |
| ld_cnt | input | 16 | Byte counter load value |
| trig | input | 1 | Start a transfer |
| dest | input | 3 | Destination code (2 main, 3 sub) |
| irq_en | input | 1 | Transfer-end interrupt enable |
| end_ack | input | 1 | Clear the pending end event |
| rd_main | input | 1 | Read strobe from the main processor |
| rd_sub | input | 1 | Read strobe from the sub processor |
| rd_valid | output | 1 | Read result present this cycle |
| rd_data | output | 16 | Big-endian word read |
| xfer_on | output | 1 | Host transfer in progress |
| busy | output | 1 | Transfer busy |
| dsr | output | 1 | Data-ready flag |
| edt | output | 1 | End-of-transfer flag |
| end_pend | output | 1 | Transfer-end event pending |
| end_irq | output | 1 | One-cycle interrupt request |
| addr_q | output | AW | Address counter |
| cnt_q | output | 16 | Byte counter |

## Verification
The bench builds the block with AW = 8, a 256-byte buffer, which it fills in full through the preload port. At this size a transfer loaded at 0xFE crosses the address wrap in a single read. The bench checks odd start addresses, reads from the processor the transfer does not name, and both the enabled and the disabled interrupt paths. It also checks a near-end read made while an earlier end event is still pending.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int unsigned CNT_W = 16;
  localparam logic [2:0] DEST_MAIN = 3'd2;
  localparam logic [2:0] DEST_SUB  = 3'd3;
  localparam logic [CNT_W-1:0] CNT_DONE = 16'hF000;

  typedef enum logic [1:0] {ZONE_RUN, ZONE_NEAR, ZONE_LAST} cnt_zone_e;

  // classify a count value after the decrement
  function automatic cnt_zone_e zone_of(input logic [CNT_W-1:0] v);
    if ($signed(v) <= 0)
      return ZONE_LAST;
    else if (v == 16'd1 || v == 16'd2)
      return ZONE_NEAR;
    else
      return ZONE_RUN;
  endfunction

  function automatic logic is_host_dest(input logic [2:0] d);
    return (d == DEST_MAIN) || (d == DEST_SUB);
  endfunction
endpackage

// File: rtl/shr_bank.sv
module shr_bank #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re)
      rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/shr_buffer.sv
module shr_buffer #(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [7:0]    pre_data,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   word
);
  localparam int unsigned IDX_W = AW - 1;

  logic [7:0] lane [2];

  // lane 0 holds even bytes, lane 1 holds odd bytes
  for (genvar b = 0; b < 2; b++) begin : g_lane
    logic lane_we;
    assign lane_we = pre_we && (pre_addr[0] == b[0]);

    shr_bank #(.IDX_W(IDX_W)) u_bank (
      .clk   (clk),
      .we    (lane_we),
      .waddr (pre_addr[AW-1:1]),
      .wdata (pre_data),
      .re    (re),
      .raddr (raddr[AW-1:1]),
      .rdata (lane[b])
    );
  end

  assign word = {lane[0], lane[1]};
endmodule

// File: rtl/shr_xfer_ctl.sv
module shr_xfer_ctl
  import shr_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_addr_en,
  input  logic [AW-1:0]    ld_addr,
  input  logic             ld_cnt_en,
  input  logic [CNT_W-1:0] ld_cnt,
  input  logic             trig,
  input  logic [2:0]       dest,
  input  logic             irq_en,
  input  logic             end_ack,
  input  logic             rd_main,
  input  logic             rd_sub,
  output logic [AW-1:0]    addr_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             xfer_on,
  output logic             busy,
  output logic             dsr,
  output logic             edt,
  output logic             end_pend,
  output logic             end_irq,
  output logic [2:0]       dest_q
);
  localparam logic [AW-1:0]    ADDR_STEP = AW'(2);
  localparam logic [CNT_W-1:0] CNT_STEP  = CNT_W'(2);

  logic [AW-1:0]    addr_r, addr_d;
  logic [CNT_W-1:0] cnt_r, cnt_d, cnt_dec;
  logic [2:0]       dest_r, dest_d;
  logic             on_r, on_d, busy_r, busy_d, dsr_r, dsr_d;
  logic             edt_r, edt_d, pend_r, pend_d, irq_r, irq_d;
  logic             adv;
  cnt_zone_e        zone;

  assign adv = on_r && ((rd_main && dest_r == DEST_MAIN) ||
                        (rd_sub  && dest_r == DEST_SUB));
  assign cnt_dec = cnt_r - CNT_STEP;
  assign zone    = zone_of(cnt_dec);

  always_comb begin
    addr_d = addr_r;
    cnt_d  = cnt_r;
    dest_d = dest_r;
    on_d   = on_r;
    busy_d = busy_r;
    dsr_d  = dsr_r;
    edt_d  = edt_r;
    pend_d = pend_r;
    irq_d  = 1'b0;

    if (end_ack)
      pend_d = 1'b0;

    if (adv) begin
      addr_d = addr_r + ADDR_STEP;
      cnt_d  = cnt_dec;
      unique case (zone)
        ZONE_LAST: begin
          cnt_d  = CNT_DONE;
          on_d   = 1'b0;
          busy_d = 1'b0;
          dsr_d  = 1'b0;
          edt_d  = 1'b1;
        end
        ZONE_NEAR: begin
          dsr_d = 1'b1;
          edt_d = 1'b1;
          if (!pend_r) begin
            pend_d = 1'b1;
            irq_d  = irq_en;
          end
        end
        default: ;
      endcase
    end

    if (trig && is_host_dest(dest)) begin
      dest_d = dest;
      on_d   = 1'b1;
      busy_d = 1'b1;
      dsr_d  = 1'b1;
      edt_d  = 1'b0;
    end

    if (ld_addr_en)
      addr_d = ld_addr;
    if (ld_cnt_en)
      cnt_d = ld_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r <= '0;
      cnt_r  <= '0;
      dest_r <= '0;
      on_r   <= 1'b0;
      busy_r <= 1'b0;
      dsr_r  <= 1'b0;
      edt_r  <= 1'b0;
      pend_r <= 1'b0;
      irq_r  <= 1'b0;
    end else begin
      addr_r <= addr_d;
      cnt_r  <= cnt_d;
      dest_r <= dest_d;
      on_r   <= on_d;
      busy_r <= busy_d;
      dsr_r  <= dsr_d;
      edt_r  <= edt_d;
      pend_r <= pend_d;
      irq_r  <= irq_d;
    end
  end

  assign addr_q   = addr_r;
  assign cnt_q    = cnt_r;
  assign dest_q   = dest_r;
  assign xfer_on  = on_r;
  assign busy     = busy_r;
  assign dsr      = dsr_r;
  assign edt      = edt_r;
  assign end_pend = pend_r;
  assign end_irq  = irq_r;
endmodule

// File: rtl/shr_host_port.sv
module shr_host_port
  import shr_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [7:0]    pre_data,
  input  logic          ld_addr_en,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_cnt_en,
  input  logic [15:0]   ld_cnt,
  input  logic          trig,
  input  logic [2:0]    dest,
  input  logic          irq_en,
  input  logic          end_ack,
  input  logic          rd_main,
  input  logic          rd_sub,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic          xfer_on,
  output logic          busy,
  output logic          dsr,
  output logic          edt,
  output logic          end_pend,
  output logic          end_irq,
  output logic [AW-1:0] addr_q,
  output logic [15:0]   cnt_q
);
  logic        rd_any, buf_re;
  logic        ok_q, ok_d, vld_q, vld_d;
  logic [15:0] buf_word;
  logic [2:0]  dest_q;

  assign rd_any = rd_main || rd_sub;
  assign buf_re = rd_any && xfer_on;

  shr_buffer #(.AW(AW)) u_buf (
    .clk      (clk),
    .pre_we   (pre_we),
    .pre_addr (pre_addr),
    .pre_data (pre_data),
    .re       (buf_re),
    .raddr    (addr_q),
    .word     (buf_word)
  );

  shr_xfer_ctl #(.AW(AW)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_addr_en (ld_addr_en),
    .ld_addr    (ld_addr),
    .ld_cnt_en  (ld_cnt_en),
    .ld_cnt     (ld_cnt),
    .trig       (trig),
    .dest       (dest),
    .irq_en     (irq_en),
    .end_ack    (end_ack),
    .rd_main    (rd_main),
    .rd_sub     (rd_sub),
    .addr_q     (addr_q),
    .cnt_q      (cnt_q),
    .xfer_on    (xfer_on),
    .busy       (busy),
    .dsr        (dsr),
    .edt        (edt),
    .end_pend   (end_pend),
    .end_irq    (end_irq),
    .dest_q     (dest_q)
  );

  always_comb begin
    vld_d = rd_any;
    ok_d  = buf_re;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ok_q  <= ok_d;
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = ok_q ? buf_word : 16'h0000;
endmodule

// File: rtl/shr_host_port_chk.sv
module shr_host_port_chk #(
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_addr_en,
  input logic          ld_cnt_en,
  input logic          trig,
  input logic [2:0]    dest,
  input logic          irq_en,
  input logic          rd_main,
  input logic          rd_sub,
  input logic          rd_valid,
  input logic [15:0]   rd_data,
  input logic          xfer_on,
  input logic          busy,
  input logic          dsr,
  input logic          edt,
  input logic          end_pend,
  input logic          end_irq,
  input logic [AW-1:0] addr_q,
  input logic [15:0]   cnt_q,
  input logic [2:0]    dest_q
);
  localparam logic [AW-1:0] STEP_A = AW'(2);
  localparam logic [15:0]   STEP_C = 16'd2;

  logic host_code, match_rd, quiet;
  assign host_code = (dest == 3'd2) || (dest == 3'd3);
  assign match_rd  = (rd_main && dest_q == 3'd2) || (rd_sub && dest_q == 3'd3);
  assign quiet     = !trig && !ld_addr_en && !ld_cnt_en;

  p_trig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trig && host_code |=> xfer_on && busy && dsr && !edt);

  p_dsr_in_xfer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dsr |-> xfer_on);

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_main || rd_sub) |=> rd_valid);

  p_idle_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_main || rd_sub) && !xfer_on && quiet
    |=> rd_data == 16'h0000 && $stable(cnt_q) && $stable(addr_q) && !xfer_on);

  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_on && match_rd && quiet
    |=> addr_q == $past(addr_q) + STEP_A);

  p_other_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_on && (rd_main || rd_sub) && !match_rd && quiet
    |=> $stable(cnt_q) && $stable(addr_q) && $stable(dsr) && $stable(edt));

  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_on) && !$past(ld_cnt_en)
    |-> edt && !dsr && !busy && cnt_q == 16'hF000);

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_on && match_rd && quiet && $signed(cnt_q - STEP_C) > 0
    |=> cnt_q == $past(cnt_q) - STEP_C);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> $rose(end_pend) && $past(irq_en));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |=> !end_irq);

  p_one_reader_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_main, rd_sub}));
endmodule

bind shr_host_port shr_host_port_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ld_addr_en (ld_addr_en),
  .ld_cnt_en  (ld_cnt_en),
  .trig       (trig),
  .dest       (dest),
  .irq_en     (irq_en),
  .rd_main    (rd_main),
  .rd_sub     (rd_sub),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .xfer_on    (xfer_on),
  .busy       (busy),
  .dsr        (dsr),
  .edt        (edt),
  .end_pend   (end_pend),
  .end_irq    (end_irq),
  .addr_q     (addr_q),
  .cnt_q      (cnt_q),
  .dest_q     (dest_q)
);

// File: tb/test_shr_host_port.sv
`timescale 1ns/1ps
module test_shr_host_port;
  localparam int AW = 8;
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pre_we, ld_addr_en, ld_cnt_en, trig, irq_en, end_ack, rd_main, rd_sub;
  logic [AW-1:0] pre_addr, ld_addr;
  logic [7:0]    pre_data;
  logic [15:0]   ld_cnt;
  logic [2:0]    dest;
  logic          rd_valid, xfer_on, busy, dsr, edt, end_pend, end_irq;
  logic [15:0]   rd_data, cnt_q;
  logic [AW-1:0] addr_q;

  logic [7:0]  model [NB];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  shr_host_port #(.AW(AW)) i_shr_host_port (
    .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .ld_addr_en(ld_addr_en), .ld_addr(ld_addr), .ld_cnt_en(ld_cnt_en), .ld_cnt(ld_cnt),
    .trig(trig), .dest(dest), .irq_en(irq_en), .end_ack(end_ack),
    .rd_main(rd_main), .rd_sub(rd_sub), .rd_valid(rd_valid), .rd_data(rd_data),
    .xfer_on(xfer_on), .busy(busy), .dsr(dsr), .edt(edt), .end_pend(end_pend),
    .end_irq(end_irq), .addr_q(addr_q), .cnt_q(cnt_q)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word_at(input logic [AW-1:0] a);
    return {model[{a[AW-1:1], 1'b0}], model[{a[AW-1:1], 1'b1}]};
  endfunction

  // monitor: pops expected words as results appear
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rd_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected result", 32'(rd_data), 32'hFFFF_FFFF);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rd_data === e, t, 32'(rd_data), 32'(e));
      end
    end
  end

  task automatic read(input bit main, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_main = main;
    rd_sub  = !main;
    @(negedge clk);
    rd_main = 1'b0;
    rd_sub  = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [15:0] c);
    ld_addr_en = 1'b1; ld_addr = a;
    ld_cnt_en  = 1'b1; ld_cnt  = c;
    @(negedge clk);
    ld_addr_en = 1'b0; ld_cnt_en = 1'b0;
  endtask

  task automatic start(input logic [2:0] d);
    trig = 1'b1; dest = d;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic ack();
    end_ack = 1'b1;
    @(negedge clk);
    end_ack = 1'b0;
  endtask

  task automatic flags(input string t, input bit xo, input bit bs, input bit ds, input bit ed, input bit pe);
    chk({xfer_on, busy, dsr, edt, end_pend} === {xo, bs, ds, ed, pe}, t,
        32'({xfer_on, busy, dsr, edt, end_pend}), 32'({xo, bs, ds, ed, pe}));
  endtask

  task automatic counters(input string t, input logic [AW-1:0] a, input logic [15:0] c);
    chk(addr_q === a && cnt_q === c, t, {8'(addr_q), 8'h0, cnt_q}, {8'(a), 8'h0, c});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    ld_addr_en = 1'b0; ld_addr = '0; ld_cnt_en = 1'b0; ld_cnt = '0;
    trig = 1'b0; dest = '0; irq_en = 1'b1; end_ack = 1'b0;
    rd_main = 1'b0; rd_sub = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    flags("R10 flags", 0, 0, 0, 0, 0);
    counters("R10 counters", '0, 16'h0000);
    chk(end_irq === 1'b0 && rd_valid === 1'b0 && rd_data === 16'h0, "R10 outputs",
        {14'h0, end_irq, rd_valid, rd_data}, 32'h0);

    // R9 preload the whole buffer
    for (int i = 0; i < NB; i++) begin
      model[i] = 8'((i * 7 + 3) ^ (i >> 3));
      pre_we = 1'b1; pre_addr = AW'(i); pre_data = model[i];
      @(negedge clk);
    end
    pre_we = 1'b0;

    // R3 read with no transfer active
    read(1'b1, 16'h0000, "R3 idle data");
    counters("R3 idle counters", '0, 16'h0000);
    flags("R3 idle flags", 0, 0, 0, 0, 0);

    // R9 load, R1 start for main
    load(8'h10, 16'h0007);
    counters("R9 load", 8'h10, 16'h0007);
    start(3'd2);
    flags("R1 start main", 1, 1, 1, 0, 0);

    // R4 other processor reads without side effects
    read(1'b0, word_at(8'h10), "R4 other cpu data");
    counters("R4 other cpu counters", 8'h10, 16'h0007);

    // R2 / R5 main reads
    read(1'b1, word_at(8'h10), "R2 word 0x10");
    counters("R5 step 1", 8'h12, 16'h0005);
    read(1'b1, word_at(8'h12), "R2 word 0x12");
    counters("R5 step 2", 8'h14, 16'h0003);
    read(1'b1, word_at(8'h14), "R2 word 0x14");
    counters("R5 step 3", 8'h16, 16'h0001);
    chk(end_irq === 1'b1, "R7 irq pulse", 32'(end_irq), 32'd1);
    flags("R7 near end flags", 1, 1, 1, 1, 1);
    read(1'b1, word_at(8'h16), "R2 word 0x16");
    chk(end_irq === 1'b0, "R7 irq one cycle", 32'(end_irq), 32'd0);
    counters("R6 end counters", 8'h18, 16'hF000);
    flags("R6 end flags", 0, 0, 0, 1, 1);

    // R3 read after end
    read(1'b1, 16'h0000, "R3 after end data");
    counters("R3 after end counters", 8'h18, 16'hF000);

    // R8 acknowledge
    ack();
    flags("R8 ack clears", 0, 0, 0, 1, 0);

    // odd start address, sub processor, interrupt disabled
    irq_en = 1'b0;
    load(8'h21, 16'h0004);
    start(3'd3);
    flags("R1 start sub", 1, 1, 1, 0, 0);
    read(1'b0, word_at(8'h21), "R2 odd addr word");
    counters("R5 odd addr step", 8'h23, 16'h0002);
    chk(end_irq === 1'b0, "R7 irq masked", 32'(end_irq), 32'd0);
    flags("R7 masked near end", 1, 1, 1, 1, 1);
    read(1'b0, word_at(8'h23), "R2 odd addr word 2");
    counters("R6 zero count end", 8'h25, 16'hF000);
    flags("R6 zero count flags", 0, 0, 0, 1, 1);

    // R8 near end while already pending: no pulse
    irq_en = 1'b1;
    load(8'h40, 16'h0003);
    start(3'd2);
    flags("R1 restart clears edt", 1, 1, 1, 0, 1);
    read(1'b1, word_at(8'h40), "R2 word 0x40");
    chk(end_irq === 1'b0, "R8 no pulse while pending", 32'(end_irq), 32'd0);
    counters("R5 count to one", 8'h42, 16'h0001);
    read(1'b1, word_at(8'h42), "R2 word 0x42");
    counters("R6 negative end", 8'h44, 16'hF000);
    ack();

    // R5 address wrap
    load(8'hFE, 16'h0010);
    start(3'd2);
    read(1'b1, word_at(8'hFE), "R2 word 0xFE");
    counters("R5 wrap", 8'h00, 16'h000E);
    read(1'b1, word_at(8'h00), "R2 word after wrap");
    counters("R5 after wrap", 8'h02, 16'h000C);

    // R1 trigger with a non-host code is ignored
    start(3'd5);
    flags("R1 other code ignored", 1, 1, 1, 0, 0);
    read(1'b0, word_at(8'h02), "R4 sub read in main transfer");
    counters("R4 sub read counters", 8'h02, 16'h000C);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all results seen", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule